// File: doc/BRIEF.md
# In-Order Pipeline Hazard Interlock

This block decides, cycle by cycle, whether the instruction sitting in the decode stage of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) may move on. The pipeline has no forwarding network. A register value therefore becomes usable only after the instruction that produces it has written it back. The decode logic hands the block the decoded instruction: a destination register with a write flag, two source registers each with a use flag, a branch flag and a small tag. The block compares the sources against the writers still in flight and returns three controls: freeze the fetch/decode register, insert a no-op into execute, and hold the program counter.

A branch in this pipeline stops any further fetch until it has completed its execute stage. The block tracks this with a small state machine. In state `ST_FLOW`, issuing a branch takes the transition *branch issue* into `ST_BR_EXEC`, which covers the cycle the branch spends in execute, with fetch held. The unconditional transition *resume fetch* then moves to `ST_BR_REFETCH`, the cycle in which the next instruction is fetched into an empty decode slot. The unconditional transition *refill done* returns to `ST_FLOW`. A data stall is not a state of its own. It is a hold that can occur only in `ST_FLOW`, while the decode contents stay put.

To rebuild a pipeline chart, the block shows which tagged instruction occupies the execute, memory and writeback stages. A free-running cycle counter and a stall-cycle counter let a sequence's total stall count be read back.

Top module: `pipe_interlock`

## Requirements
- R1: While reset is asserted and right after it, the execute, memory and writeback stages are empty, both counters read 0, no stall is signalled and a bubble is fed to execute.
- R2: An instruction that uses a source register written by an earlier instruction enters execute no earlier than three cycles after that producer entered execute, which is the cycle after the producer's writeback. A directly dependent pair therefore costs exactly two stall cycles.
- R3: A dependence on a producer that has already left writeback costs nothing: a reader three instructions behind its producer incurs no stall, and a reader two behind incurs one.
- R4: Register 0, a source whose use flag is 0, and the destination field of an instruction whose write flag is 0 never create a dependence.
- R5: When a branch moves from decode to execute, fetch is held in that cycle and in the next. The following instruction enters execute exactly three cycles after the branch did, so a branch with no data wait costs two stall cycles.
- R6: When an instruction meets both a data wait and a branch wait, only the longer one applies. A branch that is itself data-stalled adds its two branch cycles after its data stall.
- R7: In every data-stall cycle, the freeze, fetch-hold and bubble outputs are all 1, and no instruction enters execute in the next cycle.
- R8: The execute, memory and writeback occupancy outputs advance one stage per cycle, carrying the issuing instruction's tag, and each issued instruction appears in execute exactly once.
- R9: The cycle counter increases by one on every clock after reset. The stall counter increases by one for each data-stall cycle and for each of the two branch-wait cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | Decode stage holds an instruction |
| id_dst | input | REG_AW | Destination register number |
| id_writes | input | 1 | Instruction writes id_dst |
| id_src | input | NSRC*REG_AW | Source register numbers, source k at bits k*REG_AW upward |
| id_src_used | input | NSRC | Per-source use flag, bit k for source k |
| id_is_branch | input | 1 | Instruction is a branch |
| id_tag | input | TAG_W | Tag carried along for the occupancy outputs |
| stall_ifid | output | 1 | Freeze the fetch/decode register (data stall) |
| hold_fetch | output | 1 | Keep the program counter; fetch nothing new |
| bubble_ex | output | 1 | A no-op enters execute next cycle |
| ex_valid | output | 1 | Execute stage occupied |
| ex_tag | output | TAG_W | Tag in execute |
| mem_valid | output | 1 | Memory stage occupied |
| mem_tag | output | TAG_W | Tag in memory |
| wb_valid | output | 1 | Writeback stage occupied |
| wb_tag | output | TAG_W | Tag in writeback |
| cycle_count | output | CNT_W | Cycles since reset |
| stall_count | output | CNT_W | Stall cycles since reset |

## Verification
The data wait and the branch wait can land on the same instruction. A branch can read a register whose producer is still in execute, so the branch is frozen in decode while it also holds fetch. Later the branch's own hold adds two more lost cycles. The bench sets this up with a writer followed at once by a branch that reads the written register, and also with the opposite ordering, where a branch is followed by a reader of an older result. It then checks that the execute entry cycle of every tagged instruction matches the later of the two waits, and that the stall counter advances by the matching sum.

// File: rtl/pipe_ilk_pkg.sv
package pipe_ilk_pkg;

    // Control states of the interlock
    typedef enum logic [1:0] {
        ST_FLOW       = 2'd0,  // normal issue, data stalls resolved here
        ST_BR_EXEC    = 2'd1,  // branch occupies execute, fetch held
        ST_BR_REFETCH = 2'd2   // fetch resumed, decode slot still empty
    } ilk_state_e;

    // Stage indices of the in-flight tracker
    localparam int STG_EX  = 0;
    localparam int STG_MEM = 1;
    localparam int STG_WB  = 2;
    localparam int N_STG   = 3;

endpackage

// File: rtl/ilk_stage_track.sv
module ilk_stage_track #(
    parameter int REG_AW = 5,
    parameter int TAG_W  = 4,
    parameter int DEPTH  = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              issue,
    input  logic [REG_AW-1:0]                 issue_rd,
    input  logic [TAG_W-1:0]                  issue_tag,
    output logic [DEPTH-1:0]                  stg_v,
    output logic [DEPTH-1:0][REG_AW-1:0]      stg_rd,
    output logic [DEPTH-1:0][TAG_W-1:0]       stg_tag
);

    // Shadow of the execute/memory/writeback registers: one slot per stage
    for (genvar k = 0; k < DEPTH; k++) begin : g_stg
        if (k == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg_v[k]   <= 1'b0;
                    stg_rd[k]  <= '0;
                    stg_tag[k] <= '0;
                end else begin
                    stg_v[k]   <= issue;
                    stg_rd[k]  <= issue ? issue_rd : '0;
                    stg_tag[k] <= issue ? issue_tag : '0;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg_v[k]   <= 1'b0;
                    stg_rd[k]  <= '0;
                    stg_tag[k] <= '0;
                end else begin
                    stg_v[k]   <= stg_v[k-1];
                    stg_rd[k]  <= stg_rd[k-1];
                    stg_tag[k] <= stg_tag[k-1];
                end
            end
        end
    end

endmodule

// File: rtl/ilk_hazard_cmp.sv
module ilk_hazard_cmp #(
    parameter int REG_AW = 5,
    parameter int NSRC   = 2,
    parameter int NCMP   = 2
) (
    input  logic [NSRC*REG_AW-1:0]        src,
    input  logic [NSRC-1:0]               src_used,
    input  logic [NCMP-1:0]               wr_v,
    input  logic [NCMP-1:0][REG_AW-1:0]   wr_rd,
    output logic                          hazard
);

    logic [NSRC-1:0] hit;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        logic [REG_AW-1:0] reg_id;
        logic              hit_s;
        assign reg_id = src[s*REG_AW +: REG_AW];

        // A writer still before writeback blocks this source; register 0 never does
        always_comb begin
            hit_s = 1'b0;
            for (int c = 0; c < NCMP; c++) begin
                if (src_used[s] && (reg_id != '0) && wr_v[c] && (wr_rd[c] == reg_id))
                    hit_s = 1'b1;
            end
        end
        assign hit[s] = hit_s;
    end

    assign hazard = |hit;

endmodule

// File: rtl/ilk_ctrl_fsm.sv
module ilk_ctrl_fsm
    import pipe_ilk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic id_valid,
    input  logic id_is_branch,
    input  logic hazard,
    output logic issue,
    output logic stall_ifid,
    output logic hold_fetch,
    output logic bubble_ex,
    output logic stall_evt
);

    ilk_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FLOW;
        else        state_q <= state_d;
    end

    // Outputs and next state
    always_comb begin
        issue      = 1'b0;
        stall_ifid = 1'b0;
        hold_fetch = 1'b0;
        stall_evt  = 1'b0;
        state_d    = state_q;
        unique case (state_q)
            ST_FLOW: begin
                stall_ifid = id_valid && hazard;
                issue      = id_valid && !hazard;
                hold_fetch = stall_ifid || (id_valid && id_is_branch);
                stall_evt  = stall_ifid;
                if (issue && id_is_branch) state_d = ST_BR_EXEC;   // branch issue
            end
            ST_BR_EXEC: begin
                hold_fetch = 1'b1;
                stall_evt  = 1'b1;
                state_d    = ST_BR_REFETCH;                        // resume fetch
            end
            ST_BR_REFETCH: begin
                stall_evt  = 1'b1;
                state_d    = ST_FLOW;                              // refill done
            end
            default: state_d = ST_FLOW;
        endcase
        bubble_ex = !issue;
    end

endmodule

// File: rtl/ilk_counters.sv
module ilk_counters #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall_evt,
    output logic [CNT_W-1:0] cycle_count,
    output logic [CNT_W-1:0] stall_count
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cycle_count <= '0;
            stall_count <= '0;
        end else begin
            cycle_count <= cycle_count + 1'b1;
            if (stall_evt) stall_count <= stall_count + 1'b1;
        end
    end

endmodule

// File: rtl/pipe_interlock.sv
module pipe_interlock
    import pipe_ilk_pkg::*;
#(
    parameter int REG_AW = 5,
    parameter int NSRC   = 2,
    parameter int TAG_W  = 4,
    parameter int CNT_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    id_valid,
    input  logic [REG_AW-1:0]       id_dst,
    input  logic                    id_writes,
    input  logic [NSRC*REG_AW-1:0]  id_src,
    input  logic [NSRC-1:0]         id_src_used,
    input  logic                    id_is_branch,
    input  logic [TAG_W-1:0]        id_tag,
    output logic                    stall_ifid,
    output logic                    hold_fetch,
    output logic                    bubble_ex,
    output logic                    ex_valid,
    output logic [TAG_W-1:0]        ex_tag,
    output logic                    mem_valid,
    output logic [TAG_W-1:0]        mem_tag,
    output logic                    wb_valid,
    output logic [TAG_W-1:0]        wb_tag,
    output logic [CNT_W-1:0]        cycle_count,
    output logic [CNT_W-1:0]        stall_count
);

    // Writers in stages before writeback are the ones a reader must wait on
    localparam int WAIT_STAGES = N_STG - 1;

    logic                            issue;
    logic                            hazard;
    logic                            stall_evt;
    logic [REG_AW-1:0]               issue_rd;
    logic [N_STG-1:0]                stg_v;
    logic [N_STG-1:0][REG_AW-1:0]    stg_rd;
    logic [N_STG-1:0][TAG_W-1:0]     stg_tag;

    // Non-writers carry register 0, which never matches
    assign issue_rd = id_writes ? id_dst : '0;

    ilk_stage_track #(.REG_AW(REG_AW), .TAG_W(TAG_W), .DEPTH(N_STG)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (issue),
        .issue_rd  (issue_rd),
        .issue_tag (id_tag),
        .stg_v     (stg_v),
        .stg_rd    (stg_rd),
        .stg_tag   (stg_tag)
    );

    ilk_hazard_cmp #(.REG_AW(REG_AW), .NSRC(NSRC), .NCMP(WAIT_STAGES)) u_cmp (
        .src      (id_src),
        .src_used (id_src_used),
        .wr_v     (stg_v[WAIT_STAGES-1:0]),
        .wr_rd    (stg_rd[WAIT_STAGES-1:0]),
        .hazard   (hazard)
    );

    ilk_ctrl_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .id_valid     (id_valid),
        .id_is_branch (id_is_branch),
        .hazard       (hazard),
        .issue        (issue),
        .stall_ifid   (stall_ifid),
        .hold_fetch   (hold_fetch),
        .bubble_ex    (bubble_ex),
        .stall_evt    (stall_evt)
    );

    ilk_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .stall_evt   (stall_evt),
        .cycle_count (cycle_count),
        .stall_count (stall_count)
    );

    assign ex_valid  = stg_v[STG_EX];
    assign ex_tag    = stg_tag[STG_EX];
    assign mem_valid = stg_v[STG_MEM];
    assign mem_tag   = stg_tag[STG_MEM];
    assign wb_valid  = stg_v[STG_WB];
    assign wb_tag    = stg_tag[STG_WB];

endmodule

// File: rtl/pipe_interlock_chk.sv
module pipe_interlock_chk #(
    parameter int TAG_W = 4,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             id_valid,
    input logic             id_is_branch,
    input logic             stall_ifid,
    input logic             hold_fetch,
    input logic             bubble_ex,
    input logic             ex_valid,
    input logic [TAG_W-1:0] ex_tag,
    input logic             mem_valid,
    input logic [TAG_W-1:0] mem_tag,
    input logic [CNT_W-1:0] cycle_count,
    input logic [CNT_W-1:0] stall_count
);

    assert_stall_controls_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stall_ifid |-> (hold_fetch && bubble_ex));

    assert_stall_no_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stall_ifid |=> !ex_valid);

    assert_branch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && id_is_branch && !bubble_ex) |=> (hold_fetch && bubble_ex));

    assert_stage_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ex_valid |=> (mem_valid && (mem_tag == $past(ex_tag))));

    assert_cycle_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (cycle_count == CNT_W'($past(cycle_count) + 1'b1)));

    assert_stall_tally_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stall_ifid |=> (stall_count == CNT_W'($past(stall_count) + 1'b1)));

endmodule

bind pipe_interlock pipe_interlock_chk #(.TAG_W(TAG_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .id_valid     (id_valid),
    .id_is_branch (id_is_branch),
    .stall_ifid   (stall_ifid),
    .hold_fetch   (hold_fetch),
    .bubble_ex    (bubble_ex),
    .ex_valid     (ex_valid),
    .ex_tag       (ex_tag),
    .mem_valid    (mem_valid),
    .mem_tag      (mem_tag),
    .cycle_count  (cycle_count),
    .stall_count  (stall_count)
);

// File: tb/pipe_interlock_tb.sv
module pipe_interlock_tb;

    localparam int CLK_PERIOD = 10;
    localparam int REG_AW = 5;
    localparam int NSRC   = 2;
    localparam int TAG_W  = 4;
    localparam int CNT_W  = 16;
    localparam int MAXP   = 8;

    typedef struct packed {
        logic [REG_AW-1:0] rd;
        logic [REG_AW-1:0] rs1;
        logic [REG_AW-1:0] rs2;
        logic u1, u2, wr, br;
    } instr_t;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        int               off;
    } exp_t;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   id_valid = 1'b0;
    logic [REG_AW-1:0]      id_dst = '0;
    logic                   id_writes = 1'b0;
    logic [NSRC*REG_AW-1:0] id_src = '0;
    logic [NSRC-1:0]        id_src_used = '0;
    logic                   id_is_branch = 1'b0;
    logic [TAG_W-1:0]       id_tag = '0;
    logic                   stall_ifid, hold_fetch, bubble_ex;
    logic                   ex_valid, mem_valid, wb_valid;
    logic [TAG_W-1:0]       ex_tag, mem_tag, wb_tag;
    logic [CNT_W-1:0]       cycle_count, stall_count;

    instr_t prog [MAXP];
    int     plen;
    exp_t   expq [$];
    int     n_tests = 0;
    int     n_fail  = 0;
    string  cur_req = "R2";

    always #(CLK_PERIOD/2) clk = ~clk;

    pipe_interlock #(.REG_AW(REG_AW), .NSRC(NSRC), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_dst(id_dst),
        .id_writes(id_writes), .id_src(id_src), .id_src_used(id_src_used),
        .id_is_branch(id_is_branch), .id_tag(id_tag),
        .stall_ifid(stall_ifid), .hold_fetch(hold_fetch), .bubble_ex(bubble_ex),
        .ex_valid(ex_valid), .ex_tag(ex_tag), .mem_valid(mem_valid), .mem_tag(mem_tag),
        .wb_valid(wb_valid), .wb_tag(wb_tag),
        .cycle_count(cycle_count), .stall_count(stall_count)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic instr_t mk(input int rd, input int rs1, input int rs2,
                                  input bit u1, input bit u2, input bit wr, input bit br);
        instr_t t;
        t.rd = REG_AW'(rd); t.rs1 = REG_AW'(rs1); t.rs2 = REG_AW'(rs2);
        t.u1 = u1; t.u2 = u2; t.wr = wr; t.br = br;
        return t;
    endfunction

    function automatic bit reads(input instr_t c, input instr_t p);
        if (!p.wr || p.rd == '0) return 1'b0;
        return (c.u1 && c.rs1 == p.rd) || (c.u2 && c.rs2 == p.rd);
    endfunction

    // Monitor: pops expected execute entries and tracks stage travel
    int          mcyc = 0;
    int          base = 0;
    logic [1:0]  hv;
    logic [TAG_W-1:0] ht [2];
    initial begin
        hv = '0;
        forever begin
            @(negedge clk);
            mcyc++;
            if (!rst_n) begin
                hv = '0;
            end else begin
                check((wb_valid == hv[1]) && (!wb_valid || wb_tag == ht[1]), "R8",
                      "writeback occupancy two cycles after execute", int'(wb_tag), int'(ht[1]));
                if (ex_valid) begin
                    if (expq.size() == 0) begin
                        check(1'b0, "R8", "unexpected execute entry tag", int'(ex_tag), -1);
                    end else begin
                        exp_t e;
                        e = expq.pop_front();
                        if (e.tag == '0) base = mcyc;
                        check(ex_tag == e.tag, "R8", "execute tag order", int'(ex_tag), int'(e.tag));
                        check((mcyc - base) == e.off, cur_req, "execute entry offset",
                              mcyc - base, e.off);
                    end
                end
                hv[1] = hv[0]; ht[1] = ht[0];
                hv[0] = ex_valid; ht[0] = ex_tag;
            end
        end
    end

    // Driver: computes expected execute cycles from the rules, then feeds decode
    task automatic run_prog(input string req, input int hand_stalls);
        int ex_ref [MAXP];
        int pc, nidx, waited, s0, c0;
        bit nv;
        cur_req = req;
        for (int i = 0; i < plen; i++) begin
            exp_t e;
            ex_ref[i] = (i == 0) ? 0 : ex_ref[i-1] + 1;
            if (i > 0 && prog[i-1].br && ex_ref[i-1] + 3 > ex_ref[i]) ex_ref[i] = ex_ref[i-1] + 3;
            for (int j = 0; j < i; j++)
                if (reads(prog[i], prog[j]) && ex_ref[j] + 3 > ex_ref[i]) ex_ref[i] = ex_ref[j] + 3;
            e.tag = TAG_W'(i);
            e.off = ex_ref[i];
            expq.push_back(e);
        end
        check(ex_ref[plen-1] - (plen - 1) == hand_stalls, req, "rule-derived stall total",
              ex_ref[plen-1] - (plen - 1), hand_stalls);
        s0 = int'(stall_count);
        c0 = int'(cycle_count);
        pc = 0; nidx = 0; waited = 0;
        forever begin
            @(negedge clk);
            waited++;
            if (stall_ifid)
                check(hold_fetch && bubble_ex, "R7", "stall drives hold and bubble",
                      int'({hold_fetch, bubble_ex}), 3);
            if (pc == plen && !id_valid) break;
            if (stall_ifid) begin
                nv = id_valid;
            end else if (hold_fetch || pc >= plen) begin
                nv = 1'b0;
            end else begin
                nv = 1'b1; nidx = pc; pc++;
            end
            @(posedge clk);
            #1;
            id_valid     = nv;
            id_dst       = nv ? prog[nidx].rd : '0;
            id_writes    = nv && prog[nidx].wr;
            id_src       = nv ? {prog[nidx].rs2, prog[nidx].rs1} : '0;
            id_src_used  = nv ? {prog[nidx].u2, prog[nidx].u1} : '0;
            id_is_branch = nv && prog[nidx].br;
            id_tag       = TAG_W'(nidx);
        end
        repeat (6) begin
            @(negedge clk);
            waited++;
        end
        check(int'(stall_count) - s0 == hand_stalls, "R9", "stall counter delta",
              int'(stall_count) - s0, hand_stalls);
        check(int'(cycle_count) - c0 == waited, "R9", "cycle counter delta",
              int'(cycle_count) - c0, waited);
        check(expq.size() == 0, "R8", "all instructions reached execute", expq.size(), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: run did not finish, actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!ex_valid && !mem_valid && !wb_valid, "R1", "stages empty in reset",
              int'({ex_valid, mem_valid, wb_valid}), 0);
        check(cycle_count == '0 && stall_count == '0, "R1", "counters zero in reset",
              int'(cycle_count) + int'(stall_count), 0);
        check(!stall_ifid && !hold_fetch && bubble_ex, "R1", "controls idle in reset",
              int'({stall_ifid, hold_fetch, bubble_ex}), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(!ex_valid && cycle_count == CNT_W'(1) && stall_count == '0, "R1",
              "state after reset release", int'(cycle_count), 1);

        // R6 (branch wait dominates) and R2: shifted/branch/dependent chain, 6 stalls
        plen = 6;
        prog[0] = mk(18, 17, 0, 1, 0, 1, 0);
        prog[1] = mk(0, 17, 0, 1, 1, 0, 1);
        prog[2] = mk(19, 18, 0, 1, 0, 1, 0);
        prog[3] = mk(10, 19, 17, 1, 1, 1, 0);
        prog[4] = mk(20, 18, 0, 1, 0, 1, 0);
        prog[5] = mk(0, 10, 20, 1, 1, 0, 0);
        run_prog("R6", 6);

        // R2: back-to-back dependent pair costs two
        plen = 2;
        prog[0] = mk(3, 1, 2, 1, 1, 1, 0);
        prog[1] = mk(4, 0, 3, 0, 1, 1, 0);
        run_prog("R2", 2);

        // R3: distance two costs one
        plen = 3;
        prog[0] = mk(7, 1, 0, 1, 0, 1, 0);
        prog[1] = mk(6, 2, 0, 1, 0, 1, 0);
        prog[2] = mk(5, 7, 0, 1, 0, 1, 0);
        run_prog("R3", 1);

        // R3: producer already written back, zero stall
        plen = 4;
        prog[0] = mk(8, 1, 0, 1, 0, 1, 0);
        prog[1] = mk(9, 2, 0, 1, 0, 1, 0);
        prog[2] = mk(12, 2, 0, 1, 0, 1, 0);
        prog[3] = mk(13, 8, 8, 1, 1, 1, 0);
        run_prog("R3", 0);

        // R4: register 0, unused sources, non-writers create no dependence
        plen = 6;
        prog[0] = mk(0, 1, 0, 1, 0, 1, 0);
        prog[1] = mk(14, 0, 0, 1, 1, 1, 0);
        prog[2] = mk(9, 1, 0, 1, 0, 1, 0);
        prog[3] = mk(15, 9, 9, 0, 0, 1, 0);
        prog[4] = mk(11, 2, 0, 1, 0, 0, 0);
        prog[5] = mk(16, 11, 0, 1, 0, 1, 0);
        run_prog("R4", 0);

        // R5: lone branch costs two
        plen = 3;
        prog[0] = mk(21, 1, 0, 1, 0, 1, 0);
        prog[1] = mk(0, 2, 0, 1, 0, 0, 1);
        prog[2] = mk(22, 3, 0, 1, 0, 1, 0);
        run_prog("R5", 2);

        // R6: branch data-stalled on its source, then holds fetch: 2 + 2
        plen = 3;
        prog[0] = mk(5, 1, 0, 1, 0, 1, 0);
        prog[1] = mk(0, 5, 0, 1, 0, 0, 1);
        prog[2] = mk(23, 2, 0, 1, 0, 1, 0);
        run_prog("R6", 4);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule